// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per N input cycles. It models a dual-modulus prescaler that divides by 16 or 17. A main counter counts the prescaler cycles, and a 4-bit swallow counter holds the prescaler at 17 for the first few of those cycles. The divide word has two fields. The low 4 bits are the swallow count A. The remaining upper bits are the main count M. The resulting ratio is N = 16·M + A.

The main-count width is a parameter. A value of 11 gives a 15-bit word with a range of 240 to 32767. A value of 12 gives a 16-bit word with a range of 240 to 65535. A word below 240 would give M < 15, so M could be smaller than A and the ratio would not follow the formula. Such words are raised to 240. A new word is captured on a load strobe and held as pending. It replaces the running ratio only when the current output period ends, so an output period is never cut short or stretched partway through. The modulus-control output shows which division the prescaler model is using at each cycle.

Top module: `pswallow_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it, pulse_o and mod_o are 0. The ratio in force after reset is 240, so the first pulse_o appears 240 cycles after reset is released.
- R2: pulse_o is high for exactly one clock cycle per output period.
- R3: With divide word bits [3:0] = A and bits [W-1:4] = M, consecutive rising pulse_o events are exactly 16·M + A clock cycles apart.
- R4: In each output period mod_o is high for exactly 17·A cycles. These cycles run contiguously from the cycle in which pulse_o is high, so mod_o is high together with pulse_o exactly when A is nonzero.
- R5: A word whose value is below 240, zero included, is treated as 240.
- R6: A word loaded during an output period does not change that period. It governs the next full period.
- R7: While load_i is low, ratio_i has no effect on any output period.
- R8: When several words are loaded within one output period, the last one governs the next period.
- R9: The all-ones word gives a period of 2^W − 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures ratio_i as the pending divide word |
| ratio_i | input | MAIN_W+4 | Divide word: main count in the upper bits, swallow count in bits [3:0] |
| mod_o | output | 1 | Modulus control: 1 selects divide by 17, 0 selects divide by 16 |
| pulse_o | output | 1 | One-cycle pulse at the end of each divide period |

## Verification
A wrong count in any internal counter changes the spacing between pulses. This shows up at the very next pulse_o, one period after the fault. A swallow counter that leaves mod_o high too long or too briefly changes the number of mod_o-high cycles in that same period by a multiple of 17. That error appears even when the total period happens to come out right. A reload at the wrong moment shows up as a period that matches neither the old word nor the new one, or as a new word taking effect one period early. The bench measures every period together with its mod_o profile, and compares both against values computed from the words it has loaded.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  // Width of the swallow field; fixed by the 16/17 prescaler.
  localparam int SWAL_W     = 4;
  // Division of the prescaler when the modulus control is low.
  localparam int PRESC_BASE = 16;
  // Smallest main count for which M >= A always holds.
  localparam int MIN_MAIN   = 15;
  // Smallest legal ratio: 16 * 15 + 0.
  localparam int MIN_RATIO  = PRESC_BASE * MIN_MAIN;
  // Width of the prescaler state counter (holds 0..16).
  localparam int PC_W       = $clog2(PRESC_BASE + 1);
endpackage

// File: rtl/ratio_stage.sv
module ratio_stage
  import pswd_pkg::*;
#(
  parameter int MAIN_W = 12,
  localparam int W     = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [W-1:0]      word_i,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o
);
  localparam logic [W-1:0] FLOOR = W'(MIN_RATIO);

  logic [W-1:0] pend_q;
  logic [W-1:0] word_legal;

  // Words below the floor would allow M < A; raise them to the floor.
  always_comb begin
    if (word_i < FLOOR) word_legal = FLOOR;
    else                word_legal = word_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= FLOOR;
    else if (load_i) pend_q <= word_legal;
  end

  assign main_o = pend_q[W-1:SWAL_W];
  assign swal_o = pend_q[SWAL_W-1:0];

  // R7: without a load strobe the pending word holds its value
  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(pend_q));
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
  import pswd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div17_i,
  output logic tick_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_state;

  // Divide by 17 uses states 0..16; divide by 16 uses states 0..15.
  assign last_state = div17_i ? PC_W'(PRESC_BASE) : PC_W'(PRESC_BASE - 1);
  assign tick_o     = (pc_q == last_state);

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else             pc_q <= pc_q + PC_W'(1);
  end

  // R4: the seventeenth state is reached only under divide by 17
  a_r4_extra_state_needs_mod: assert property (@(posedge clk) disable iff (rst)
    (pc_q == PC_W'(PRESC_BASE)) |-> div17_i);
endmodule

// File: rtl/swallow_ctl.sv
module swallow_ctl
  import pswd_pkg::*;
#(
  parameter int MAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [SWAL_W-1:0] swal_i,
  output logic              div17_o,
  output logic              wrap_o
);
  logic [MAIN_W-1:0] mc_q;
  logic [SWAL_W-1:0] sc_q;
  logic              mod_q;

  // The period ends on the prescaler tick that closes the last main cycle.
  assign wrap_o  = tick_i && (mc_q == MAIN_W'(1));
  assign div17_o = mod_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q  <= MAIN_W'(MIN_MAIN);
      sc_q  <= '0;
      mod_q <= 1'b0;
    end else if (wrap_o) begin
      mc_q  <= main_i;
      sc_q  <= swal_i;
      mod_q <= (swal_i != '0);
    end else if (tick_i) begin
      mc_q <= mc_q - MAIN_W'(1);
      if (sc_q != '0) begin
        sc_q  <= sc_q - SWAL_W'(1);
        mod_q <= (sc_q != SWAL_W'(1));
      end
    end
  end

  // R3: swallow cycles never outnumber the main cycles left
  a_r3_swallow_within_main: assert property (@(posedge clk) disable iff (rst)
    (MAIN_W'(sc_q) <= mc_q) && (mc_q != '0));

  // R6: counters move only on prescaler ticks
  a_r6_counters_idle_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($stable(mc_q) && $stable(sc_q)));
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswd_pkg::*;
#(
  parameter int MAIN_W = 12,
  localparam int W     = MAIN_W + SWAL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] ratio_i,
  output logic         mod_o,
  output logic         pulse_o
);
  logic [MAIN_W-1:0] next_main;
  logic [SWAL_W-1:0] next_swal;
  logic              div17;
  logic              tick;
  logic              wrap;
  logic              pulse_q;

  ratio_stage #(.MAIN_W(MAIN_W)) u_stage (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .word_i (ratio_i),
    .main_o (next_main),
    .swal_o (next_swal)
  );

  dual_mod_prescaler u_presc (
    .clk     (clk),
    .rst     (rst),
    .div17_i (div17),
    .tick_o  (tick)
  );

  swallow_ctl #(.MAIN_W(MAIN_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .main_i  (next_main),
    .swal_i  (next_swal),
    .div17_o (div17),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= wrap;
  end

  assign pulse_o = pulse_q;
  assign mod_o   = div17;

  // R2: the output pulse lasts one cycle
  a_r2_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  // R4: divide-by-17 stretches begin only at a period boundary
  a_r4_mod_rises_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_o) |-> pulse_o);

  // R1: outputs are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_o && !mod_o));
endmodule

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb;
  localparam int MAIN_W = 12;
  localparam int W      = MAIN_W + 4;
  localparam int WDOG   = 180000;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_i;
  logic [W-1:0] ratio_i;
  logic         mod_o;
  logic         pulse_o;

  int checks = 0;
  int errors = 0;
  int pend   = 240;

  always #2 clk = ~clk;

  pswallow_divider #(.MAIN_W(MAIN_W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .ratio_i (ratio_i),
    .mod_o   (mod_o),
    .pulse_o (pulse_o)
  );

  function automatic int legal(input int w);
    return (w < 240) ? 240 : w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at the sample where pulse_o is high; returns at the next one.
  task automatic run_period(input string tag, input bit ld1, input int w1,
                            input bit ld2, input int w2);
    int cnt  = 0;
    int modc = 0;
    int exp  = pend;
    bit mfirst;
    bit p1 = 1'b0;
    mfirst = mod_o;
    do begin
      if (mod_o) modc++;
      if (cnt == 0 && ld1) begin
        ratio_i = W'(w1); load_i = 1'b1;
      end else if (cnt == 7 && ld2) begin
        ratio_i = W'(w2); load_i = 1'b1;
      end else if (cnt == 3) begin
        ratio_i = W'($urandom); load_i = 1'b0;  // R7: ignored without load
      end else begin
        load_i = 1'b0;
      end
      @(negedge clk);
      cnt++;
      if (cnt == 1) p1 = pulse_o;
    end while (!pulse_o);
    if (ld1) pend = legal(w1);
    if (ld2) pend = legal(w2);
    check(cnt == exp, tag, cnt, exp);
    check(p1 == 1'b0, "R2", int'(p1), 0);
    check(modc == 17 * (exp % 16), "R4", modc, 17 * (exp % 16));
    check(mfirst == ((exp % 16) != 0), "R4", int'(mfirst), int'((exp % 16) != 0));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd5848));
    rst = 1'b1; load_i = 1'b0; ratio_i = '0;
    repeat (4) @(negedge clk);
    check(!pulse_o && !mod_o, "R1", int'({pulse_o, mod_o}), 0);
    rst = 1'b0;
    first = 0;
    do begin
      @(negedge clk);
      first++;
    end while (!pulse_o);
    check(first == 240, "R1", first, 240);

    run_period("R6", 1'b1, 255,   1'b0, 0);   // old 240 still in force
    run_period("R3", 1'b1, 5,     1'b0, 0);   // M=15 A=15 -> 255
    run_period("R5", 1'b1, 0,     1'b0, 0);   // 5 raised to 240
    run_period("R5", 1'b1, 256,   1'b0, 0);   // 0 raised to 240
    run_period("R3", 1'b1, 65535, 1'b0, 0);   // 256, A=0
    run_period("R9", 1'b1, 1000,  1'b1, 777); // all ones -> 65535
    run_period("R8", 1'b0, 0,     1'b0, 0);   // last load 777 wins
    run_period("R7", 1'b0, 0,     1'b0, 0);   // no load, still 777

    for (int i = 0; i < 24; i++) begin
      int w;
      if ($urandom_range(0, 4) == 0) w = int'($urandom_range(0, 239));
      else                           w = 240 + int'($urandom_range(0, 1800));
      run_period("R3", 1'b1, w, 1'b0, 0);
    end
    run_period("R3", 1'b0, 0, 1'b0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule